// File: doc/BRIEF.md
# Repeated Bit-Oriented Signalling Message Sender

This block places a short bit-oriented signalling message on a serial data-link channel and repeats it a programmed number of times. A processor programs it through a small register port: a control word that holds the message code, the repeat count and a packet-mode bit, a per-event interrupt enable word, a block-wide interrupt enable, an interrupt control word that selects how status is cleared, and a status word with a start-of-transfer flag and an end-of-transfer flag.

A transfer begins when the processor writes the control word with the packet-mode bit at zero while the sender is idle. The sender captures the code and the count, raises the start flag and shifts one bit onto the line each time the channel's bit strobe is high. When the last repetition has left, it raises the end flag. A single active-high, registered interrupt output combines the enabled flags under the block-wide enable.

Top module: `bomtx_top`

## Requirements
- R1: A write to the control word (address 0) with bit 6 at zero while the sender is idle starts a transfer and captures the code from bits [5:0] and the repeat count from bits [15:7]; a control write with bit 6 at one starts nothing.
- R2: The start-of-transfer flag (status word, address 4, bit 0) is set on the clock edge that accepts the starting write.
- R3: Each repetition is 16 line bits, sent one per clock edge on which bit_en is high: eight ones, a zero, the six code bits least significant first, then a zero.
- R4: A repeat count of N sends N repetitions and a count of zero sends one; the end-of-transfer flag (status bit 1) is set on the edge that sends the final bit and not earlier.
- R5: ser_out is one after reset and on every bit_en edge while no transfer is active.
- R6: With the clear-mode bit (address 3, bit 0) at zero, a status flag stays set across reads; writing a one at its bit position of address 4 clears it and a zero leaves it.
- R7: With the clear-mode bit at one, a read of address 4 returns the flags as they stand and clears them.
- R8: When a flag is set and cleared on the same edge, it ends set.
- R9: The per-event enables sit at address 1 (bit 0 for start, bit 1 for end) and the block-wide enable at address 2 bit 0; irq is one on the edge after the block enable is one and some enabled flag is set, and zero otherwise.
- R10: A starting control write made while a transfer is active neither sets the start flag nor changes the code or count being sent; after the end flag has been raised a new start is accepted.
- R11: After reset irq is zero, status, enables and clear mode read as zero, and the control word reads 0x0040.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for the addressed word |
| bit_en | input | 1 | Data-link bit strobe, one line bit per high cycle |
| ser_out | output | 1 | Serial data-link output |
| irq | output | 1 | Combined interrupt, active high |

## Verification
The checker assumes that the processor never raises reg_wr and reg_rd together and that a status read or write is a single-cycle strobe, so that a flag which is held across a cycle without any access to address 4 must still be set afterwards. It also takes bit_en as a clean one-cycle strobe per line bit. The directed stimulus issues every register access as a one-cycle strobe with one idle cycle between accesses, and only combines a read with a bit strobe in the one scenario that deliberately makes a clear meet a new end event.

// File: rtl/bomtx_pkg.sv
package bomtx_pkg;

   localparam int ADDR_W = 3;

   typedef enum logic [ADDR_W-1:0] {
      REG_CTRL = 3'd0,
      REG_IEN  = 3'd1,
      REG_BLK  = 3'd2,
      REG_ICR  = 3'd3,
      REG_STAT = 3'd4
   } reg_addr_e;

   localparam int ST_SOT = 0;
   localparam int ST_EOT = 1;
   localparam int NUM_ST = 2;

   typedef enum logic {
      SND_IDLE = 1'b0,
      SND_RUN  = 1'b1
   } snd_state_e;

endpackage

// File: rtl/bomtx_regs.sv
module bomtx_regs
   import bomtx_pkg::*;
#(
   parameter int CODE_W = 6,
   parameter int DATA_W = 16,
   localparam int REP_W = DATA_W - CODE_W - 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_i,
   input  logic                rd_i,
   input  logic [ADDR_W-1:0]   addr_i,
   input  logic [DATA_W-1:0]   wdata_i,
   output logic [DATA_W-1:0]   rdata_o,
   input  logic                busy_i,
   input  logic                eot_evt_i,
   output logic                start_o,
   output logic [CODE_W-1:0]   code_o,
   output logic [REP_W-1:0]    rep_o,
   output logic [NUM_ST-1:0]   ien_o,
   output logic                blk_en_o,
   output logic [NUM_ST-1:0]   stat_o
);

   localparam int MODE_BIT = CODE_W;
   localparam int REP_LSB  = CODE_W + 1;

   if (DATA_W < CODE_W + 2) begin : g_bad_width
      $error("bomtx_regs: DATA_W too small for code, mode and count");
   end
   if (DATA_W < NUM_ST) begin : g_bad_stat
      $error("bomtx_regs: DATA_W narrower than the status word");
   end

   logic [CODE_W-1:0] code_q;
   logic              pkt_q;
   logic [REP_W-1:0]  rep_q;
   logic [NUM_ST-1:0] ien_q;
   logic              blk_q;
   logic              rur_q;
   logic [NUM_ST-1:0] stat_q;
   logic [NUM_ST-1:0] stat_set;
   logic [NUM_ST-1:0] stat_clr;

   logic wr_ctrl, wr_ien, wr_blk, wr_icr, wr_stat, rd_stat;

   always_comb begin
      wr_ctrl = wr_i && (addr_i == REG_CTRL);
      wr_ien  = wr_i && (addr_i == REG_IEN);
      wr_blk  = wr_i && (addr_i == REG_BLK);
      wr_icr  = wr_i && (addr_i == REG_ICR);
      wr_stat = wr_i && (addr_i == REG_STAT);
      rd_stat = rd_i && (addr_i == REG_STAT);
   end

   assign start_o = wr_ctrl && !wdata_i[MODE_BIT] && !busy_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q <= '0;
         pkt_q  <= 1'b1;
         rep_q  <= '0;
      end else if (wr_ctrl) begin
         code_q <= wdata_i[CODE_W-1:0];
         pkt_q  <= wdata_i[MODE_BIT];
         rep_q  <= wdata_i[DATA_W-1:REP_LSB];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ien_q <= '0;
         blk_q <= 1'b0;
         rur_q <= 1'b0;
      end else begin
         if (wr_ien) ien_q <= wdata_i[NUM_ST-1:0];
         if (wr_blk) blk_q <= wdata_i[0];
         if (wr_icr) rur_q <= wdata_i[0];
      end
   end

   always_comb begin
      stat_set         = '0;
      stat_set[ST_SOT] = start_o;
      stat_set[ST_EOT] = eot_evt_i;
   end

   for (genvar gi = 0; gi < NUM_ST; gi++) begin : g_stat
      assign stat_clr[gi] = (rd_stat && rur_q) ||
                            (wr_stat && !rur_q && wdata_i[gi]);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)               stat_q[gi] <= 1'b0;
         else if (stat_set[gi])    stat_q[gi] <= 1'b1;
         else if (stat_clr[gi])    stat_q[gi] <= 1'b0;
      end
   end

   always_comb begin
      rdata_o = '0;
      unique case (addr_i)
         REG_CTRL: begin
            rdata_o[CODE_W-1:0]        = code_q;
            rdata_o[MODE_BIT]          = pkt_q;
            rdata_o[DATA_W-1:REP_LSB]  = rep_q;
         end
         REG_IEN:  rdata_o[NUM_ST-1:0] = ien_q;
         REG_BLK:  rdata_o[0]          = blk_q;
         REG_ICR:  rdata_o[0]          = rur_q;
         REG_STAT: rdata_o[NUM_ST-1:0] = stat_q;
         default:  rdata_o             = '0;
      endcase
   end

   assign code_o   = wdata_i[CODE_W-1:0];
   assign rep_o    = wdata_i[DATA_W-1:REP_LSB];
   assign ien_o    = ien_q;
   assign blk_en_o = blk_q;
   assign stat_o   = stat_q;

endmodule

// File: rtl/bomtx_ser.sv
module bomtx_ser
   import bomtx_pkg::*;
#(
   parameter int CODE_W = 6,
   parameter int REP_W  = 9,
   parameter int FLAG_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [CODE_W-1:0] code_i,
   input  logic [REP_W-1:0]  rep_i,
   input  logic              bit_en_i,
   output logic              busy_o,
   output logic              eot_o,
   output logic              ser_o
);

   localparam int FRAME_LEN = FLAG_W + CODE_W + 2;
   localparam int CNT_W     = $clog2(FRAME_LEN);

   if (FLAG_W < 1) begin : g_bad_flag
      $error("bomtx_ser: FLAG_W must be at least one");
   end
   if (REP_W < 1) begin : g_bad_rep
      $error("bomtx_ser: REP_W must be at least one");
   end

   function automatic logic [FRAME_LEN-1:0] build_frame(input logic [CODE_W-1:0] c);
      build_frame = {1'b0, c, 1'b0, {FLAG_W{1'b1}}};
   endfunction

   snd_state_e           state_q;
   logic [CODE_W-1:0]    code_q;
   logic [FRAME_LEN-1:0] shreg_q;
   logic [CNT_W-1:0]     cnt_q;
   logic [REP_W-1:0]     reps_q;
   logic                 ser_q;
   logic                 last_bit;
   logic                 last_rep;
   logic                 step;

   assign step     = (state_q == SND_RUN) && bit_en_i;
   assign last_bit = (cnt_q == CNT_W'(FRAME_LEN - 1));
   assign last_rep = (reps_q == REP_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SND_IDLE;
         code_q  <= '0;
         shreg_q <= '1;
         cnt_q   <= '0;
         reps_q  <= '0;
      end else if (start_i) begin
         state_q <= SND_RUN;
         code_q  <= code_i;
         shreg_q <= build_frame(code_i);
         cnt_q   <= '0;
         reps_q  <= (rep_i == '0) ? REP_W'(1) : rep_i;
      end else if (step) begin
         if (last_bit) begin
            cnt_q   <= '0;
            shreg_q <= build_frame(code_q);
            reps_q  <= reps_q - REP_W'(1);
            if (last_rep) state_q <= SND_IDLE;
         end else begin
            cnt_q   <= cnt_q + CNT_W'(1);
            shreg_q <= {1'b1, shreg_q[FRAME_LEN-1:1]};
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ser_q <= 1'b1;
      else if (bit_en_i) ser_q <= (state_q == SND_RUN) ? shreg_q[0] : 1'b1;
   end

   assign busy_o = (state_q == SND_RUN);
   assign eot_o  = step && last_bit && last_rep;
   assign ser_o  = ser_q;

endmodule

// File: rtl/bomtx_irq.sv
module bomtx_irq
   import bomtx_pkg::*;
#(
   parameter int N_SRC = NUM_ST
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] stat_i,
   input  logic [N_SRC-1:0] ien_i,
   input  logic             blk_en_i,
   output logic             irq_o
);

   if (N_SRC < 1) begin : g_bad_src
      $error("bomtx_irq: at least one source required");
   end

   logic [N_SRC-1:0] gated;

   for (genvar gi = 0; gi < N_SRC; gi++) begin : g_gate
      assign gated[gi] = stat_i[gi] & ien_i[gi];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_o <= 1'b0;
      else        irq_o <= blk_en_i & (|gated);
   end

endmodule

// File: rtl/bomtx_top.sv
module bomtx_top
   import bomtx_pkg::*;
#(
   parameter int CODE_W = 6,
   parameter int FLAG_W = 8,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [2:0]        reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              bit_en,
   output logic              ser_out,
   output logic              irq
);

   localparam int REP_W = DATA_W - CODE_W - 1;

   logic              busy;
   logic              eot_evt;
   logic              start;
   logic [CODE_W-1:0] code;
   logic [REP_W-1:0]  rep;
   logic [NUM_ST-1:0] ien;
   logic              blk_en;
   logic [NUM_ST-1:0] stat;

   bomtx_regs #(.CODE_W(CODE_W), .DATA_W(DATA_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_i      (reg_wr),
      .rd_i      (reg_rd),
      .addr_i    (reg_addr),
      .wdata_i   (reg_wdata),
      .rdata_o   (reg_rdata),
      .busy_i    (busy),
      .eot_evt_i (eot_evt),
      .start_o   (start),
      .code_o    (code),
      .rep_o     (rep),
      .ien_o     (ien),
      .blk_en_o  (blk_en),
      .stat_o    (stat)
   );

   bomtx_ser #(.CODE_W(CODE_W), .REP_W(REP_W), .FLAG_W(FLAG_W)) u_ser (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start),
      .code_i   (code),
      .rep_i    (rep),
      .bit_en_i (bit_en),
      .busy_o   (busy),
      .eot_o    (eot_evt),
      .ser_o    (ser_out)
   );

   bomtx_irq #(.N_SRC(NUM_ST)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .stat_i   (stat),
      .ien_i    (ien),
      .blk_en_i (blk_en),
      .irq_o    (irq)
   );

endmodule

// File: rtl/bomtx_chk.sv
module bomtx_chk
   import bomtx_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic              reg_rd,
   input logic [2:0]        reg_addr,
   input logic              bit_en,
   input logic              ser_out,
   input logic              irq,
   input logic              busy,
   input logic              start,
   input logic              eot_evt,
   input logic [NUM_ST-1:0] ien,
   input logic              blk_en,
   input logic [NUM_ST-1:0] stat
);

   logic stat_acc;
   assign stat_acc = (reg_wr || reg_rd) && (reg_addr == REG_STAT);

   assert_sot_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> stat[ST_SOT]);

   assert_eot_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
      eot_evt |=> stat[ST_EOT]);

   assert_eot_in_transfer_R4: assert property (@(posedge clk) disable iff (!rst_n)
      eot_evt |-> busy);

   assert_idle_mark_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && bit_en) |=> ser_out);

   assert_status_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (stat[ST_EOT] && !stat_acc) |=> stat[ST_EOT]);

   assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (eot_evt && stat_acc) |=> stat[ST_EOT]);

   assert_block_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !blk_en |=> !irq);

   assert_irq_raise_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_en && ien[ST_EOT] && stat[ST_EOT]) |=> irq);

   assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !stat[ST_SOT] && !stat_acc) |=> !stat[ST_SOT]);

endmodule

bind bomtx_top bomtx_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .reg_wr   (reg_wr),
   .reg_rd   (reg_rd),
   .reg_addr (reg_addr),
   .bit_en   (bit_en),
   .ser_out  (ser_out),
   .irq      (irq),
   .busy     (busy),
   .start    (start),
   .eot_evt  (eot_evt),
   .ien      (ien),
   .blk_en   (blk_en),
   .stat     (stat)
);

// File: tb/tb_bomtx_top.sv
module tb_bomtx_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic        reg_rd = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        bit_en = 1'b0;
   logic        ser_out;
   logic        irq;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   localparam logic [2:0] A_CTRL = 3'd0, A_IEN = 3'd1, A_BLK = 3'd2,
                          A_ICR = 3'd3, A_STAT = 3'd4;

   bomtx_top dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .bit_en(bit_en), .ser_out(ser_out), .irq(irq)
   );

   always #5 clk = ~clk;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] exp_frame(input logic [5:0] c);
      logic [15:0] f;
      for (int i = 0; i < 8; i++) f[i] = 1'b1;
      f[8] = 1'b0;
      for (int i = 0; i < 6; i++) f[9+i] = c[i];
      f[15] = 1'b0;
      return f;
   endfunction

   function automatic logic [15:0] ctrl_word(input logic [8:0] rep, input logic pkt, input logic [5:0] c);
      return {rep, pkt, c};
   endfunction

   task automatic reg_write(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic reg_read(input logic [2:0] a, output logic [15:0] d);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic strobe(output logic b);
      @(negedge clk);
      bit_en = 1'b1;
      @(negedge clk);
      bit_en = 1'b0;
      b = ser_out;
   endtask

   task automatic get_frame(output logic [15:0] f);
      logic b;
      for (int i = 0; i < 16; i++) begin
         strobe(b);
         f[i] = b;
      end
   endtask

   task automatic t_reset();
      logic [15:0] d;
      logic b;
      chk("R5 line idles high after reset", ser_out, 1);
      chk("R11 irq low after reset", irq, 0);
      reg_read(A_STAT, d); chk("R11 status zero", d, 0);
      reg_read(A_CTRL, d); chk("R11 control reset value", d, 16'h0040);
      reg_read(A_IEN, d);  chk("R11 enables zero", d, 0);
      reg_read(A_ICR, d);  chk("R11 clear mode zero", d, 0);
      reg_write(A_CTRL, ctrl_word(9'd1, 1'b1, 6'h15));
      reg_read(A_STAT, d); chk("R1 packet-mode write starts nothing", d, 0);
      strobe(b);           chk("R1 R5 line stays high", b, 1);
   endtask

   task automatic t_basic();
      logic [15:0] d, f;
      logic b;
      reg_write(A_IEN, 16'h3);
      reg_write(A_BLK, 16'h1);
      reg_write(A_CTRL, ctrl_word(9'd2, 1'b0, 6'h25));
      @(negedge clk);
      chk("R9 irq after start flag", irq, 1);
      reg_read(A_STAT, d); chk("R2 start flag set", d, 16'h1);
      reg_read(A_STAT, d); chk("R6 read does not clear", d, 16'h1);
      get_frame(f);        chk("R3 first repetition", f, exp_frame(6'h25));
      for (int i = 0; i < 15; i++) begin
         strobe(b);
         f[i] = b;
      end
      reg_read(A_STAT, d); chk("R4 end flag not before last bit", d, 16'h1);
      strobe(b); f[15] = b;
      chk("R1 R3 second repetition", f, exp_frame(6'h25));
      reg_read(A_STAT, d); chk("R4 end flag after last bit", d, 16'h3);
      reg_write(A_STAT, 16'h1);
      reg_read(A_STAT, d); chk("R6 write one clears only that bit", d, 16'h2);
      reg_write(A_STAT, 16'h2);
      reg_read(A_STAT, d); chk("R6 write one clears end flag", d, 16'h0);
      chk("R9 irq drops with status", irq, 0);
      strobe(b);           chk("R5 idle line after transfer", b, 1);
   endtask

   task automatic t_rep_zero();
      logic [15:0] d, f;
      logic b;
      reg_write(A_CTRL, ctrl_word(9'd0, 1'b0, 6'h0A));
      get_frame(f);        chk("R3 frame with count zero", f, exp_frame(6'h0A));
      reg_read(A_STAT, d); chk("R4 count zero ends after one", d, 16'h3);
      strobe(b);           chk("R4 R5 no second repetition", b, 1);
      reg_write(A_STAT, 16'h3);
   endtask

   task automatic t_gating();
      logic [15:0] d, f;
      reg_write(A_IEN, 16'h0);
      reg_write(A_BLK, 16'h1);
      reg_write(A_CTRL, ctrl_word(9'd0, 1'b0, 6'h01));
      @(negedge clk); @(negedge clk);
      chk("R9 disabled source gives no irq", irq, 0);
      reg_write(A_IEN, 16'h1);
      @(negedge clk);
      chk("R9 enabled start source raises irq", irq, 1);
      reg_write(A_BLK, 16'h0);
      @(negedge clk);
      chk("R9 block enable off masks irq", irq, 0);
      reg_write(A_BLK, 16'h1);
      reg_write(A_IEN, 16'h2);
      @(negedge clk);
      chk("R9 only end source enabled, end not set", irq, 0);
      get_frame(f);
      @(negedge clk);
      chk("R9 irq from end flag", irq, 1);
      reg_write(A_STAT, 16'h3);
      @(negedge clk);
      chk("R9 irq clears with status", irq, 0);
      reg_read(A_STAT, d); chk("R6 status cleared by write", d, 0);
   endtask

   task automatic t_read_clear();
      logic [15:0] d, f;
      reg_write(A_ICR, 16'h1);
      reg_write(A_CTRL, ctrl_word(9'd0, 1'b0, 6'h3F));
      reg_read(A_STAT, d); chk("R7 read returns start flag", d, 16'h1);
      reg_read(A_STAT, d); chk("R7 read cleared start flag", d, 16'h0);
      get_frame(f);        chk("R3 all-ones code frame", f, exp_frame(6'h3F));
      reg_read(A_STAT, d); chk("R7 read returns end flag", d, 16'h2);
      reg_read(A_STAT, d); chk("R7 read cleared end flag", d, 16'h0);
   endtask

   task automatic t_collision();
      logic [15:0] d;
      logic b;
      reg_write(A_CTRL, ctrl_word(9'd0, 1'b0, 6'h12));
      reg_read(A_STAT, d);
      for (int i = 0; i < 15; i++) strobe(b);
      @(negedge clk);
      bit_en = 1'b1; reg_rd = 1'b1; reg_addr = A_STAT;
      #1 d = reg_rdata;
      @(negedge clk);
      bit_en = 1'b0; reg_rd = 1'b0;
      chk("R8 read before end event sees none", d, 16'h0);
      chk("R3 final trailing zero", ser_out, 0);
      reg_read(A_STAT, d); chk("R8 end event wins over read clear", d, 16'h2);
      reg_read(A_STAT, d); chk("R7 later read clears", d, 16'h0);
      reg_write(A_ICR, 16'h0);
   endtask

   task automatic t_busy_ignore();
      logic [15:0] d, f;
      logic b;
      reg_write(A_CTRL, ctrl_word(9'd2, 1'b0, 6'h05));
      for (int i = 0; i < 5; i++) begin
         strobe(b);
         f[i] = b;
      end
      reg_write(A_STAT, 16'h1);
      reg_write(A_CTRL, ctrl_word(9'd1, 1'b0, 6'h3A));
      reg_read(A_STAT, d); chk("R10 start during transfer ignored", d, 16'h0);
      for (int i = 5; i < 16; i++) begin
         strobe(b);
         f[i] = b;
      end
      chk("R10 first repetition unchanged", f, exp_frame(6'h05));
      get_frame(f);        chk("R10 count kept, code kept", f, exp_frame(6'h05));
      reg_read(A_STAT, d); chk("R10 end flag only", d, 16'h2);
      reg_write(A_STAT, 16'h3);
      reg_write(A_CTRL, ctrl_word(9'd0, 1'b0, 6'h3A));
      reg_read(A_STAT, d); chk("R10 new start accepted after end", d, 16'h1);
      get_frame(f);        chk("R1 new code captured", f, exp_frame(6'h3A));
      strobe(b);           chk("R5 idle after single repetition", b, 1);
      reg_write(A_STAT, 16'h3);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_rep_zero();
      t_gating();
      t_read_clear();
      t_collision();
      t_busy_ignore();
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule